// File: doc/BRIEF.md
# Control Register Logic Unit

This block keeps two 8-bit processor control registers: a condition-code register (CCR) and an extended control register (EXR). Upstream decode presents one operation at a time on a valid/ready input channel. The operation can load a register from a 16-bit data word, store a register out as a 16-bit word, or combine a register with an 8-bit immediate using AND, OR or XOR. Both register values are always visible on plain output pins.

Stores leave the block on a valid/ready output channel. While a store word is waiting and the consumer holds `st_ready` low, the output word is frozen and the input channel applies back-pressure. A new operation is accepted only when the output stage is empty, or when it empties in the same cycle. A word-size transfer uses only the upper byte of the 16-bit word. A byte-size transfer uses the lower byte.

Top module: `crlu_top`

## Requirements
- R1: A synchronous reset (`rst_n` low at a rising edge) sets CCR to `RST_CCR`, EXR to `RST_EXR` and `st_valid` to 0.
- R2: A load (`in_op`=3'b001) with `in_word`=0 writes `in_data[7:0]` into the selected register at the accepting edge.
- R3: A load with `in_word`=1 writes `in_data[15:8]` into the selected register. `in_data[7:0]` is ignored.
- R4: AND-immediate (`in_op`=3'b011) replaces the selected register with its bitwise AND with `in_imm`.
- R5: OR-immediate (`in_op`=3'b100) and XOR-immediate (`in_op`=3'b101) replace the selected register with its bitwise OR or XOR with `in_imm`.
- R6: No-operation (`in_op`=3'b000), store (3'b010) and the unused codes 3'b110 and 3'b111 leave both registers unchanged.
- R7: `in_sel`=0 targets CCR and `in_sel`=1 targets EXR. The register that is not selected keeps its value. No register changes unless `in_valid` and `in_ready` are both high at the edge.
- R8: An accepted store sets `st_valid` at the next edge. With `in_word`=1, `st_data` is {register, 8'h00}. With `in_word`=0, it is {8'h00, register}.
- R9: `in_ready` equals `!st_valid || st_ready`. While `st_valid` is high and `st_ready` is low, `st_valid` and `st_data` stay stable and operations presented on the input are not taken. `st_valid` clears after a handshake unless a new store is accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_op | input | 3 | Operation code |
| in_sel | input | 1 | 0 selects CCR, 1 selects EXR |
| in_word | input | 1 | 1 means word-size transfer, 0 means byte-size |
| in_imm | input | DW | Immediate operand for the logic operations |
| in_data | input | 2*DW | Load source word |
| ccr_q | output | DW | Condition-code register value |
| exr_q | output | DW | Extended control register value |
| st_valid | output | 1 | Store word valid |
| st_ready | input | 1 | Consumer accepts the store word |
| st_data | output | 2*DW | Store word |

## Verification
The bench builds the block with DW=8 and overrides the reset values to 8'hA5 and 8'h3C. These values differ from each other and from all-zero or all-one patterns, so a reset that swaps the registers or clears them shows up at once. `st_ready` is driven low about half the time. This keeps stores stalled for several cycles and makes both back-pressure and the same-cycle drain-and-refill case common. The random stimulus covers all eight operation codes with random selects, sizes and data, so the ignored lower byte of word loads and the unused codes are exercised.

// File: rtl/crlu_pkg.sv
`timescale 1ns/1ps
package crlu_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'b000,
    OP_LOAD  = 3'b001,
    OP_STORE = 3'b010,
    OP_AND   = 3'b011,
    OP_OR    = 3'b100,
    OP_XOR   = 3'b101,
    OP_RSV6  = 3'b110,
    OP_RSV7  = 3'b111
  } op_e;

  localparam int NREG = 2;
  localparam int SEL_CCR = 0;
  localparam int SEL_EXR = 1;
endpackage

// File: rtl/crlu_alu.sv
`timescale 1ns/1ps
module crlu_alu
  import crlu_pkg::*;
#(
  parameter int DW = 8
) (
  input  op_e               op,
  input  logic              word,
  input  logic [DW-1:0]     cur,
  input  logic [DW-1:0]     imm,
  input  logic [2*DW-1:0]   data,
  output logic [DW-1:0]     nxt,
  output logic              upd
);
  logic [DW-1:0] load_val;

  // Word transfers use the upper half of the word, byte transfers the lower half.
  assign load_val = word ? data[2*DW-1:DW] : data[DW-1:0];

  always_comb begin
    nxt = cur;
    upd = 1'b0;
    unique case (op)
      OP_LOAD: begin nxt = load_val;  upd = 1'b1; end
      OP_AND:  begin nxt = cur & imm; upd = 1'b1; end
      OP_OR:   begin nxt = cur | imm; upd = 1'b1; end
      OP_XOR:  begin nxt = cur ^ imm; upd = 1'b1; end
      default: begin nxt = cur;       upd = 1'b0; end
    endcase
  end
endmodule

// File: rtl/crlu_regs.sv
`timescale 1ns/1ps
module crlu_regs #(
  parameter int                 DW      = 8,
  parameter int                 NR      = 2,
  parameter logic [NR*DW-1:0]   RST_VAL = '0,
  localparam int                IW      = (NR > 1) ? $clog2(NR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IW-1:0]     idx,
  input  logic [DW-1:0]     wdata,
  output logic [NR*DW-1:0]  q
);
  for (genvar g = 0; g < NR; g++) begin : g_reg
    logic [DW-1:0] r;
    always_ff @(posedge clk) begin
      if (!rst_n)
        r <= RST_VAL[g*DW +: DW];
      else if (we && (idx == IW'(g)))
        r <= wdata;
    end
    assign q[g*DW +: DW] = r;
  end
endmodule

// File: rtl/crlu_stout.sv
`timescale 1ns/1ps
module crlu_stout #(
  parameter int DW = 8,
  localparam int WW = 2*DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic          word,
  input  logic [DW-1:0] val,
  output logic          take_ok,
  output logic          st_valid,
  input  logic          st_ready,
  output logic [WW-1:0] st_data
);
  logic [WW-1:0] fmt;

  assign fmt     = word ? {val, {DW{1'b0}}} : {{DW{1'b0}}, val};
  assign take_ok = !st_valid || st_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_valid <= 1'b0;
      st_data  <= '0;
    end else if (cap) begin
      st_valid <= 1'b1;
      st_data  <= fmt;
    end else if (st_ready) begin
      st_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/crlu_top.sv
`timescale 1ns/1ps
module crlu_top
  import crlu_pkg::*;
#(
  parameter int            DW      = 8,
  parameter logic [DW-1:0] RST_CCR = 8'h80,
  parameter logic [DW-1:0] RST_EXR = 8'h07
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [2:0]      in_op,
  input  logic            in_sel,
  input  logic            in_word,
  input  logic [DW-1:0]   in_imm,
  input  logic [2*DW-1:0] in_data,
  output logic [DW-1:0]   ccr_q,
  output logic [DW-1:0]   exr_q,
  output logic            st_valid,
  input  logic            st_ready,
  output logic [2*DW-1:0] st_data
);
  localparam logic [NREG*DW-1:0] RST_ALL = {RST_EXR, RST_CCR};

  op_e                 op;
  logic                fire;
  logic                upd;
  logic [DW-1:0]       cur;
  logic [DW-1:0]       nxt;
  logic [NREG*DW-1:0]  q;

  assign op   = op_e'(in_op);
  assign fire = in_valid && in_ready;
  assign cur  = q[in_sel*DW +: DW];

  crlu_alu #(.DW(DW)) u_alu (
    .op(op), .word(in_word), .cur(cur), .imm(in_imm),
    .data(in_data), .nxt(nxt), .upd(upd)
  );

  crlu_regs #(.DW(DW), .NR(NREG), .RST_VAL(RST_ALL)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(fire && upd), .idx(in_sel),
    .wdata(nxt), .q(q)
  );

  crlu_stout #(.DW(DW)) u_st (
    .clk(clk), .rst_n(rst_n), .cap(fire && (op == OP_STORE)),
    .word(in_word), .val(cur), .take_ok(in_ready),
    .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data)
  );

  assign ccr_q = q[SEL_CCR*DW +: DW];
  assign exr_q = q[SEL_EXR*DW +: DW];
endmodule

// File: rtl/crlu_chk.sv
`timescale 1ns/1ps
module crlu_chk #(
  parameter int            DW      = 8,
  parameter logic [DW-1:0] RST_CCR = 8'h80,
  parameter logic [DW-1:0] RST_EXR = 8'h07
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [2:0]      in_op,
  input logic            in_sel,
  input logic            in_word,
  input logic [DW-1:0]   in_imm,
  input logic [2*DW-1:0] in_data,
  input logic [DW-1:0]   ccr_q,
  input logic [DW-1:0]   exr_q,
  input logic            st_valid,
  input logic            st_ready,
  input logic [2*DW-1:0] st_data
);
  logic fire;
  assign fire = in_valid && in_ready;

  AST_RESET_VALUES: assert property (@(posedge clk)
    !rst_n |=> (ccr_q == RST_CCR && exr_q == RST_EXR && !st_valid)); // R1

  AST_WORD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == 3'b001 && in_word && !in_sel |=> ccr_q == $past(in_data[2*DW-1:DW])); // R3

  AST_AND_IMM: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == 3'b011 && !in_sel |=> ccr_q == ($past(ccr_q) & $past(in_imm))); // R4

  AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == 3'b000 |=> $stable(ccr_q) && $stable(exr_q)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(ccr_q) && $stable(exr_q)); // R7

  AST_UNSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !in_sel |=> $stable(exr_q)); // R7

  AST_STORE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == 3'b010 && !in_word |=> st_valid && st_data[2*DW-1:DW] == '0); // R8

  AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |=> st_valid && $stable(st_data)); // R9

  AST_STALL_NOTAKE: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |-> !in_ready); // R9
endmodule

bind crlu_top crlu_chk #(.DW(DW), .RST_CCR(RST_CCR), .RST_EXR(RST_EXR)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_sel(in_sel), .in_word(in_word), .in_imm(in_imm),
  .in_data(in_data), .ccr_q(ccr_q), .exr_q(exr_q), .st_valid(st_valid),
  .st_ready(st_ready), .st_data(st_data)
);

// File: tb/sim_crlu_top.sv
`timescale 1ns/1ps
module sim_crlu_top;
  localparam int            DW = 8;
  localparam logic [7:0]    RC = 8'hA5;
  localparam logic [7:0]    RE = 8'h3C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = 3'b000;
  logic        in_sel = 1'b0;
  logic        in_word = 1'b0;
  logic [7:0]  in_imm = '0;
  logic [15:0] in_data = '0;
  logic [7:0]  ccr_q, exr_q;
  logic        st_valid;
  logic        st_ready = 1'b1;
  logic [15:0] st_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0]  m_ccr, m_exr;
  logic        m_sv;
  logic [15:0] m_sd;

  always #2 clk = ~clk;

  crlu_top #(.DW(DW), .RST_CCR(RC), .RST_EXR(RE)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_sel(in_sel), .in_word(in_word), .in_imm(in_imm),
    .in_data(in_data), .ccr_q(ccr_q), .exr_q(exr_q), .st_valid(st_valid),
    .st_ready(st_ready), .st_data(st_data)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] f_next(input logic [2:0] op, input logic word,
                                        input logic [7:0] cur, input logic [7:0] imm,
                                        input logic [15:0] data);
    case (op)
      3'b001:  return word ? data[15:8] : data[7:0];
      3'b011:  return cur & imm;
      3'b100:  return cur | imm;
      3'b101:  return cur ^ imm;
      default: return cur;
    endcase
  endfunction

  function automatic string f_tag(input logic [2:0] op, input logic word);
    case (op)
      3'b001:  return word ? "R3" : "R2";
      3'b011:  return "R4";
      3'b100, 3'b101: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check_outputs(input string tc, input string te);
    chk({tc, " ccr"}, {8'h00, ccr_q}, {8'h00, m_ccr});
    chk({te, " exr"}, {8'h00, exr_q}, {8'h00, m_exr});
    chk("R8/R9 st_valid", {15'h0, st_valid}, {15'h0, m_sv});
    if (m_sv) chk("R8 st_data", st_data, m_sd);
  endtask

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic cyc(input logic vld, input logic [2:0] op, input logic sel,
                     input logic word, input logic [7:0] imm, input logic [15:0] data,
                     input logic srdy);
    logic        rdy, fire;
    logic [7:0]  cur, nv;
    logic        nsv;
    logic [15:0] nsd;
    string       tc, te;
    in_valid = vld; in_op = op; in_sel = sel; in_word = word;
    in_imm = imm; in_data = data; st_ready = srdy;
    #1;
    rdy = !m_sv || srdy;
    chk("R9 in_ready", {15'h0, in_ready}, {15'h0, rdy});
    fire = vld && rdy;
    cur = sel ? m_exr : m_ccr;
    nv = f_next(op, word, cur, imm, data);
    nsv = m_sv; nsd = m_sd;
    if (fire && op == 3'b010) begin
      nsv = 1'b1;
      nsd = word ? {cur, 8'h00} : {8'h00, cur};
    end else if (m_sv && srdy) begin
      nsv = 1'b0;
    end
    tc = "R7"; te = "R7";
    if (vld && !rdy) begin tc = "R9"; te = "R9"; end
    if (fire) begin
      if (sel) te = f_tag(op, word); else tc = f_tag(op, word);
      if (sel) m_exr = nv; else m_ccr = nv;
    end
    @(posedge clk);
    m_sv = nsv; m_sd = nsd;
    @(negedge clk);
    check_outputs(tc, te);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0;
    @(posedge clk); @(posedge clk);
    m_ccr = RC; m_exr = RE; m_sv = 1'b0; m_sd = '0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 ccr", {8'h00, ccr_q}, {8'h00, RC});
    chk("R1 exr", {8'h00, exr_q}, {8'h00, RE});
    chk("R1 st_valid", {15'h0, st_valid}, 16'h0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // Directed corner cases
    cyc(1, 3'b001, 0, 0, 8'h00, 16'hFF5A, 1);   // R2 byte load CCR
    cyc(1, 3'b001, 1, 1, 8'h00, 16'hC311, 1);   // R3 word load EXR, low byte ignored
    cyc(1, 3'b011, 0, 0, 8'h0F, 16'h0000, 1);   // R4
    cyc(1, 3'b101, 1, 0, 8'hFF, 16'h0000, 1);   // R5 xor
    cyc(1, 3'b100, 0, 0, 8'h80, 16'h0000, 1);   // R5 or
    cyc(1, 3'b110, 0, 0, 8'h00, 16'hFFFF, 1);   // R6 unused code
    cyc(1, 3'b111, 1, 1, 8'h00, 16'hFFFF, 1);   // R6 unused code
    cyc(1, 3'b010, 1, 1, 8'h00, 16'h0000, 0);   // R8 word store, stalled
    cyc(1, 3'b001, 0, 0, 8'h00, 16'h0011, 0);   // R9 load ignored during stall
    cyc(1, 3'b011, 1, 0, 8'h00, 16'h0000, 0);   // R9 and ignored during stall
    cyc(1, 3'b010, 0, 0, 8'h00, 16'h0000, 1);   // R9 drain and refill, byte store
    cyc(0, 3'b000, 0, 0, 8'h00, 16'h0000, 1);   // R8 drain
    cyc(1, 3'b000, 0, 0, 8'hFF, 16'hFFFF, 1);   // R6 nop
    cyc(0, 3'b001, 0, 1, 8'h00, 16'hABCD, 1);   // R7 no valid
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      cyc($urandom_range(0, 3) != 0, 3'($urandom_range(0, 7)), 1'($urandom),
          1'($urandom), 8'($urandom), 16'($urandom), 1'($urandom));
      if (i == 2000) begin
        do_reset();
      end
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule